// File: doc/BRIEF.md
# ADC Conversion Sequencer with Host Status Registers

This block sits between a byte-wide host register port and a multichannel analog-to-digital converter. The host picks an acquisition mode and an interrupt enable in the control/status register. It picks a channel and a gain code in the gain/channel register. It collects each 12-bit result through a low byte and a high byte. Writing the gain/channel register is what starts work. In single mode it requests exactly one conversion. In the three continuous modes it arms the sequencer, which then launches conversions from an internal pacer or from an external clock. In the two triggered modes the sequencer also waits for an external trigger edge first.

The converter is driven through a start/complete handshake. A start pulse carries the channel and the gain code. A one-cycle completion strobe returns the sample. The sequencer stores the sample, raises a done flag and asserts an interrupt while interrupts are enabled. An unread result that is overwritten by a new one raises an error flag.

The sequencing state machine has three states. `CS_IDLE` waits for a start decision. `CS_LAUNCH` drives the start pulse for one cycle. `CS_WAIT` holds until the completion strobe. The transitions are:
- `CS_IDLE` to `CS_LAUNCH` when a start fires.
- `CS_LAUNCH` to `CS_WAIT` unconditionally.
- `CS_WAIT` to `CS_IDLE` on completion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The host registers sit at fixed offsets: 0 is control/status, 1 is gain/channel, 2 is the sample low byte and 3 is the sample high byte. Control/status reads back as follows:
  - bit 7: done
  - bit 6: error
  - bit 5: busy
  - bits 4:3: always 0
  - bit 2: interrupt enable
  - bits 1:0: mode

  Gain/channel reads back gain in bits 7:6 and channel in bits 5:0, as written.
- R2: After reset every register and flag reads 0, the start output is low and the interrupt is low.
- R3: In mode 00, each write to offset 1 produces exactly one start pulse, one cycle wide. The pulse presents the gain code from bits 7:6 and the channel from the low channel bits.
- R4: Busy (status bit 5) reads 1 from the cycle the start pulse is driven until the completion strobe is accepted.
- R5: On completion the sample is stored and done is set. Offset 2 returns sample bits 7:0. Offset 3 returns, in bits 3:0, sample bits 11:8 as latched by the most recent offset-2 read, with bits 7:4 reading 0.
- R6: Reading offset 3 clears done. A completion in the same cycle leaves done set.
- R7: A completion while done is still set (and not being cleared that cycle) sets the error flag, and the new sample replaces the old one. Writing the control/status register with bit 4 set clears the error flag; a new error in that same cycle wins.
- R8: The interrupt output is high exactly when interrupt enable and done are both 1.
- R9: In mode 01, a write to offset 1 arms the sequencer. The internal pacer then launches a conversion every PACE_DIV cycles. Any write to offset 0 disarms it and cancels a pending single request.
- R10: In mode 10, a write to offset 1 arms the sequencer but no conversion starts until a rising edge of the external trigger. After that edge, conversions follow the internal pacer every PACE_DIV cycles.
- R11: In mode 11, once armed and after a rising edge of the external trigger, each rising edge of the external clock starts one conversion. External clock edges before the trigger start nothing.
- R12: A pacer tick or external clock edge that arrives while a conversion is in progress is dropped. A mode-00 write made while busy is held and served once the converter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (fires read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ext_trig | input | 1 | External trigger, rising edge arms triggered modes |
| ext_clk | input | 1 | External conversion clock for mode 11 |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | CH_W | Channel presented to the converter |
| conv_gain | output | 2 | Gain code presented to the converter |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_sample | input | SAMPLE_W | Sample valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check on every cycle that:
- the start output is a single-cycle pulse;
- busy only drops after a completion;
- the error flag only rises when done was already set;
- done follows a completion and clears after a high-byte read;
- no continuous-mode start fires while disarmed.

Only the bench scenarios can show that:
- the pacer spacing is exactly PACE_DIV;
- triggered modes stay silent until the trigger edge;
- external clock edges are counted one for one;
- ticks are dropped during long conversions;
- a single-mode request made while busy is still served.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE      = 2'b00,
        MODE_PACED       = 2'b01,
        MODE_TRIG_PACED  = 2'b10,
        MODE_TRIG_EXTCLK = 2'b11
    } acq_mode_t;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_LAUNCH = 2'd1,
        CS_WAIT   = 2'd2
    } conv_state_t;

    localparam logic [1:0] OFS_CTRL   = 2'd0;
    localparam logic [1:0] OFS_GAIN   = 2'd1;
    localparam logic [1:0] OFS_DAT_LO = 2'd2;
    localparam logic [1:0] OFS_DAT_HI = 2'd3;

endpackage

// File: rtl/adc_host_regs.sv
module adc_host_regs
    import adc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output acq_mode_t   mode_o,
    output logic        ie_o,
    output logic [1:0]  gain_o,
    output logic [5:0]  chan_o,
    output logic        wr_ctrl_o,
    output logic        wr_gain_o,
    output logic        clr_err_o,
    output logic        rd_lo_o,
    output logic        rd_hi_o
);

    acq_mode_t  mode_q;
    logic       ie_q;
    logic [1:0] gain_q;
    logic [5:0] chan_q;
    logic       unused_wbits;

    assign wr_ctrl_o = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_gain_o = bus_wr && (bus_addr == OFS_GAIN);
    assign clr_err_o = wr_ctrl_o && bus_wdata[4];
    assign rd_lo_o   = bus_rd && (bus_addr == OFS_DAT_LO);
    assign rd_hi_o   = bus_rd && (bus_addr == OFS_DAT_HI);

    assign unused_wbits = ^{bus_wdata[7:5], bus_wdata[3]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SINGLE;
            ie_q   <= 1'b0;
            gain_q <= 2'b00;
            chan_q <= 6'd0;
        end else begin
            if (wr_ctrl_o) begin
                mode_q <= acq_mode_t'(bus_wdata[1:0]);
                ie_q   <= bus_wdata[2];
            end
            if (wr_gain_o) begin
                gain_q <= bus_wdata[7:6];
                chan_q <= bus_wdata[5:0];
            end
        end
    end

    assign mode_o = mode_q;
    assign ie_o   = ie_q;
    assign gain_o = gain_q;
    assign chan_o = chan_q;

endmodule

// File: rtl/adc_start_gen.sv
module adc_start_gen
    import adc_seq_pkg::*;
#(
    parameter int PACE_DIV = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  acq_mode_t mode,
    input  logic      wr_ctrl,
    input  logic      wr_gain,
    input  logic      ext_trig,
    input  logic      ext_clk,
    input  logic      fsm_idle,
    output logic      fire_o
);

    localparam int CNT_W = (PACE_DIV > 2) ? $clog2(PACE_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PACE_DIV - 1);

    logic             req_pend;
    logic             armed;
    logic             trig_seen;
    logic             trig_q;
    logic             eclk_q;
    logic [CNT_W-1:0] pace_cnt;
    logic             trig_edge;
    logic             eclk_edge;
    logic             pace_run;
    logic             pace_tick;
    logic             triggered_mode;

    assign trig_edge      = ext_trig && !trig_q;
    assign eclk_edge      = ext_clk && !eclk_q;
    assign triggered_mode = (mode == MODE_TRIG_PACED) || (mode == MODE_TRIG_EXTCLK);
    assign pace_run       = armed && ((mode == MODE_PACED) ||
                                      ((mode == MODE_TRIG_PACED) && trig_seen));
    assign pace_tick      = pace_run && (pace_cnt == CNT_LAST);

    always_comb begin
        fire_o = 1'b0;
        if (fsm_idle) begin
            unique case (mode)
                MODE_SINGLE:      fire_o = req_pend;
                MODE_PACED:       fire_o = pace_tick;
                MODE_TRIG_PACED:  fire_o = pace_tick;
                MODE_TRIG_EXTCLK: fire_o = armed && trig_seen && eclk_edge;
                default:          fire_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_pend  <= 1'b0;
            armed     <= 1'b0;
            trig_seen <= 1'b0;
            trig_q    <= 1'b0;
            eclk_q    <= 1'b0;
            pace_cnt  <= '0;
        end else begin
            trig_q <= ext_trig;
            eclk_q <= ext_clk;

            if (wr_ctrl)
                req_pend <= 1'b0;
            else if (wr_gain && (mode == MODE_SINGLE))
                req_pend <= 1'b1;
            else if (fire_o && (mode == MODE_SINGLE))
                req_pend <= 1'b0;

            if (wr_ctrl)
                armed <= 1'b0;
            else if (wr_gain && (mode != MODE_SINGLE))
                armed <= 1'b1;

            if (wr_ctrl || wr_gain)
                trig_seen <= 1'b0;
            else if (armed && triggered_mode && trig_edge)
                trig_seen <= 1'b1;

            if (wr_gain || !pace_run)
                pace_cnt <= '0;
            else if (pace_cnt == CNT_LAST)
                pace_cnt <= '0;
            else
                pace_cnt <= pace_cnt + 1'b1;
        end
    end

    AST_NO_UNARMED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && (mode != MODE_SINGLE)) |-> armed); // R9

    AST_TRIG_BEFORE_EXTCLK_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && (mode == MODE_TRIG_EXTCLK)) |-> trig_seen); // R11

endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic conv_done,
    output logic conv_start,
    output logic busy,
    output logic idle,
    output logic complete
);

    conv_state_t state_q;
    conv_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:   if (fire) state_d = CS_LAUNCH;
            CS_LAUNCH: state_d = CS_WAIT;
            CS_WAIT:   if (conv_done) state_d = CS_IDLE;
            default:   state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        conv_start = 1'b0;
        busy       = 1'b1;
        idle       = 1'b0;
        complete   = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
                busy = 1'b0;
                idle = 1'b1;
            end
            CS_LAUNCH: conv_start = 1'b1;
            CS_WAIT:   complete = conv_done;
            default: begin
                busy = 1'b0;
                idle = 1'b1;
            end
        endcase
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R3

    AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(conv_done)); // R4

endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                complete,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                rd_lo,
    input  logic                rd_hi,
    input  logic                clr_err,
    output logic [7:0]          lo_byte_o,
    output logic [7:0]          hi_byte_o,
    output logic                done_o,
    output logic                err_o
);

    localparam int HI_W  = SAMPLE_W - 8;
    localparam int PAD_W = 8 - HI_W;

    logic [SAMPLE_W-1:0] data_q;
    logic [HI_W-1:0]     hold_q;
    logic                done_q;
    logic                err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            hold_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (complete)
                data_q <= sample;
            if (rd_lo)
                hold_q <= data_q[SAMPLE_W-1:8];
            if (complete)
                done_q <= 1'b1;
            else if (rd_hi)
                done_q <= 1'b0;
            if (complete && done_q && !rd_hi)
                err_q <= 1'b1;
            else if (clr_err)
                err_q <= 1'b0;
        end
    end

    assign lo_byte_o = data_q[7:0];
    assign hi_byte_o = {{PAD_W{1'b0}}, hold_q};
    assign done_o    = done_q;
    assign err_o     = err_q;

    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(done_o)); // R7

    AST_DONE_ON_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> done_o); // R5

    AST_HI_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && !complete) |=> !done_o); // R6

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W     = 6,
    parameter int SAMPLE_W = 12,
    parameter int PACE_DIV = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic                ext_trig,
    input  logic                ext_clk,
    output logic                conv_start,
    output logic [CH_W-1:0]     conv_chan,
    output logic [1:0]          conv_gain,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_sample,
    output logic                irq
);

    acq_mode_t  mode;
    logic       ie;
    logic [1:0] gain;
    logic [5:0] chan;
    logic       wr_ctrl, wr_gain, clr_err, rd_lo, rd_hi;
    logic       fire, busy, idle, complete;
    logic [7:0] lo_byte, hi_byte;
    logic       done, err;

    adc_host_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .mode_o    (mode),
        .ie_o      (ie),
        .gain_o    (gain),
        .chan_o    (chan),
        .wr_ctrl_o (wr_ctrl),
        .wr_gain_o (wr_gain),
        .clr_err_o (clr_err),
        .rd_lo_o   (rd_lo),
        .rd_hi_o   (rd_hi)
    );

    adc_start_gen #(.PACE_DIV(PACE_DIV)) u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .wr_ctrl  (wr_ctrl),
        .wr_gain  (wr_gain),
        .ext_trig (ext_trig),
        .ext_clk  (ext_clk),
        .fsm_idle (idle),
        .fire_o   (fire)
    );

    adc_conv_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .busy       (busy),
        .idle       (idle),
        .complete   (complete)
    );

    adc_result_store #(.SAMPLE_W(SAMPLE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .complete  (complete),
        .sample    (conv_sample),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .clr_err   (clr_err),
        .lo_byte_o (lo_byte),
        .hi_byte_o (hi_byte),
        .done_o    (done),
        .err_o     (err)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL:   bus_rdata = {done, err, busy, 2'b00, ie, mode};
            OFS_GAIN:   bus_rdata = {gain, chan};
            OFS_DAT_LO: bus_rdata = lo_byte;
            OFS_DAT_HI: bus_rdata = hi_byte;
            default:    bus_rdata = 8'h00;
        endcase
    end

    assign conv_chan = chan[CH_W-1:0];
    assign conv_gain = gain;
    assign irq       = ie && done;

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && ie)); // R8

endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;

    localparam int CH_W = 6, SAMPLE_W = 12, PD = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic ext_trig = 1'b0, ext_clk = 1'b0;
    logic conv_start, irq;
    logic [CH_W-1:0] conv_chan;
    logic [1:0] conv_gain;
    logic conv_done = 1'b0;
    logic [SAMPLE_W-1:0] conv_sample = '0;

    always #5 clk = ~clk;

    adc_seq_ctrl #(.CH_W(CH_W), .SAMPLE_W(SAMPLE_W), .PACE_DIV(PD)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig), .ext_clk(ext_clk),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_gain(conv_gain),
        .conv_done(conv_done), .conv_sample(conv_sample), .irq(irq));

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model
    int cnv_lat = 2, cnv_cnt = -1, seq = 0;
    int last_sample = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            conv_done = 1'b0; cnv_cnt = -1;
        end else begin
            conv_done = 1'b0;
            if (cnv_cnt > 0) cnv_cnt--;
            else if (cnv_cnt == 0) begin
                last_sample = (12'hA5C ^ (seq * 291)) & 12'hFFF;
                conv_sample = last_sample[SAMPLE_W-1:0];
                conv_done = 1'b1;
                seq++;
                cnv_cnt = -1;
            end
            if (conv_start) cnv_cnt = cnv_lat - 1;
        end
    end

    // behavioural reference model
    int m_mode, m_ie, m_done, m_err, m_ph, m_req, m_armed, m_seen, m_cnt, m_tq, m_cq;
    int m_data, m_hold, m_gain, m_chan;
    bit w0, w1, r2, r3, te, ce, run, tick, fire, cmp;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= 0; m_ie <= 0; m_done <= 0; m_err <= 0; m_ph <= 0; m_req <= 0;
            m_armed <= 0; m_seen <= 0; m_cnt <= 0; m_tq <= 0; m_cq <= 0;
            m_data <= 0; m_hold <= 0; m_gain <= 0; m_chan <= 0;
        end else begin
            w0 = bus_wr && bus_addr == 0;  w1 = bus_wr && bus_addr == 1;
            r2 = bus_rd && bus_addr == 2;  r3 = bus_rd && bus_addr == 3;
            te = ext_trig && m_tq == 0;    ce = ext_clk && m_cq == 0;
            run  = m_armed != 0 && (m_mode == 1 || (m_mode == 2 && m_seen != 0));
            tick = run && m_cnt == PD - 1;
            fire = m_ph == 0 && (m_mode == 0 ? m_req != 0 :
                                 m_mode == 3 ? (m_armed != 0 && m_seen != 0 && ce) : tick);
            cmp  = m_ph == 2 && conv_done;
            m_tq <= ext_trig; m_cq <= ext_clk;
            if (w0) begin m_mode <= bus_wdata & 3; m_ie <= (bus_wdata >> 2) & 1; end
            if (w1) begin m_gain <= bus_wdata >> 6; m_chan <= bus_wdata & 63; end
            if (w0) m_req <= 0; else if (w1 && m_mode == 0) m_req <= 1; else if (fire && m_mode == 0) m_req <= 0;
            if (w0) m_armed <= 0; else if (w1 && m_mode != 0) m_armed <= 1;
            if (w0 || w1) m_seen <= 0; else if (m_armed != 0 && m_mode >= 2 && te) m_seen <= 1;
            if (w1 || !run || m_cnt == PD - 1) m_cnt <= 0; else m_cnt <= m_cnt + 1;
            case (m_ph)
                0: if (fire) m_ph <= 1;
                1: m_ph <= 2;
                default: if (conv_done) m_ph <= 0;
            endcase
            if (cmp) m_data <= conv_sample;
            if (r2) m_hold <= m_data >> 8;
            if (cmp) m_done <= 1; else if (r3) m_done <= 0;
            if (cmp && m_done != 0 && !r3) m_err <= 1; else if (w0 && bus_wdata[4]) m_err <= 0;
        end
    end

    function automatic int exp_rdata(input int a);
        case (a)
            0: return (m_done << 7) | (m_err << 6) | ((m_ph != 0) << 5) | (m_ie << 2) | m_mode;
            1: return (m_gain << 6) | m_chan;
            2: return m_data & 255;
            default: return m_hold;
        endcase
    endfunction

    // per-cycle compare and start bookkeeping
    int cyc = 0, starts = 0, last_start = -1, int_mode = 0, int_bad = 0;
    always @(posedge clk) begin
        #2;
        cyc++;
        if (rst_n) begin
            check("R3 conv_start vs model", conv_start, m_ph == 1);
            check("R8 irq vs model", irq, m_ie & m_done);
            check("R1 bus_rdata vs model", bus_rdata, exp_rdata(bus_addr));
            if (conv_start) begin
                check("R3 conv_gain vs model", conv_gain, m_gain);
                check("R3 conv_chan vs model", conv_chan, m_chan);
                if (last_start >= 0 && int_mode == 1 && cyc - last_start != PD) int_bad++;
                if (last_start >= 0 && int_mode == 2 &&
                    (((cyc - last_start) % PD) != 0 || (cyc - last_start) < cnv_lat)) int_bad++;
                starts++;
                last_start = cyc;
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); bus_addr = a[1:0]; bus_wdata = d[7:0]; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask
    task automatic rd(input int a, output int v);
        @(negedge clk); bus_addr = a[1:0]; bus_rd = 1; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask
    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic pulse_eclk(input int hi, input int lo);
        @(negedge clk); ext_clk = 1; idle_cycles(hi); ext_clk = 0; idle_cycles(lo);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    int v, s0, lo, hi;
    initial begin
        idle_cycles(3); rst_n = 1; idle_cycles(1);
        // R2 reset
        rd(0, v); check("R2 status after reset", v, 0);
        rd(1, v); check("R2 gain/chan after reset", v, 0);
        check("R2 irq after reset", irq, 0);
        check("R2 conv_start after reset", conv_start, 0);

        // R1 reserved bits, R3/R5/R6/R8 single conversion
        wr(0, 8'hFF); rd(0, v); check("R1 bits 4:3 read zero", v & 8'h18, 0);
        check("R1 ie and mode read back", v & 8'h07, 7);
        wr(0, 8'h04); s0 = starts;
        wr(1, 8'hC5); rd(1, v); check("R1 gain/chan read back", v, 8'hC5);
        idle_cycles(10);
        check("R3 one start per write", starts - s0, 1);
        rd(0, v); check("R5 done set", (v >> 7) & 1, 1); check("R4 busy clear after done", (v >> 5) & 1, 0);
        check("R8 irq with ie and done", irq, 1);
        rd(2, lo); check("R5 low byte", lo, last_sample & 255);
        rd(3, hi); check("R5 high byte latched", hi, last_sample >> 8);
        rd(0, v); check("R6 done cleared by high read", (v >> 7) & 1, 0);
        check("R8 irq low after clear", irq, 0);

        // R7 overrun error and clear
        wr(1, 8'h12); idle_cycles(10); wr(1, 8'h12); idle_cycles(10);
        rd(0, v); check("R7 error on overrun", (v >> 6) & 1, 1);
        rd(2, lo); check("R7 newest sample kept", lo, last_sample & 255);
        wr(0, 8'h14); rd(0, v); check("R7 error cleared by bit 4", (v >> 6) & 1, 0);
        check("R7 mode/ie unchanged by clear", v & 7, 4);
        rd(3, v);

        // R9 paced mode
        wr(0, 8'h01); int_mode = 1; s0 = starts; last_start = -1;
        wr(1, 8'h03); idle_cycles(60);
        check("R9 pacer spacing equals PACE_DIV", int_bad, 0);
        check("R9 pacer produced starts", (starts - s0) >= 6, 1);
        wr(0, 8'h11); idle_cycles(5); s0 = starts; idle_cycles(30);
        check("R9 disarmed by control write", starts - s0, 0);
        rd(3, v); wr(0, 8'h10);

        // R10 triggered paced mode
        wr(0, 8'h02); wr(1, 8'h07); s0 = starts; idle_cycles(40);
        check("R10 no start before trigger", starts - s0, 0);
        last_start = -1; ext_trig = 1; idle_cycles(2); ext_trig = 0; idle_cycles(60);
        check("R10 paced after trigger", (starts - s0) >= 5, 1);
        check("R10 spacing after trigger", int_bad, 0);
        int_mode = 0;
        wr(0, 8'h13); rd(3, v); wr(0, 8'h13);

        // R11 external clock mode
        wr(1, 8'h09); s0 = starts;
        for (int i = 0; i < 3; i++) pulse_eclk(3, 3);
        idle_cycles(5); check("R11 ext clock ignored before trigger", starts - s0, 0);
        ext_trig = 1; idle_cycles(2); ext_trig = 0; idle_cycles(2);
        s0 = starts;
        for (int i = 0; i < 4; i++) pulse_eclk(4, 12);
        idle_cycles(5); check("R11 one start per ext clock edge", starts - s0, 4);

        // R4, R12 long conversions
        cnv_lat = 20; wr(0, 8'h11); int_mode = 2; last_start = -1; s0 = starts;
        wr(1, 8'h01); idle_cycles(120);
        check("R12 ticks dropped while busy", int_bad, 0);
        check("R12 fewer starts than ticks", (starts - s0) < 120 / PD, 1);
        int_mode = 0;
        wr(0, 8'h10); idle_cycles(30); rd(3, v); wr(0, 8'h10);
        s0 = starts;
        wr(1, 8'h02); idle_cycles(4);
        rd(0, v); check("R4 busy during conversion", (v >> 5) & 1, 1);
        wr(1, 8'h02); idle_cycles(70);
        check("R12 held single request served", starts - s0, 2);
        rd(0, v); check("R4 busy clear when idle", (v >> 5) & 1, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule